// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software programs it through a small register slave: a source address, a destination address, a byte count and a control word, and then sets the trigger bit. The engine moves the data one unit at a time. For each unit it reads from the source on a simple bus-master port, keeps the read data in a one-word holding buffer, and then writes that data to the destination. The master port uses request, write, address, size, write data, read data, ready and error. A request stays up until ready is seen. An error response that arrives together with ready marks that access as failed.

The channel has three transfer directions. Memory-to-memory moves 32-bit words and does not wait. In the two peripheral directions, the engine waits for the peripheral request input before each unit, and the unit is 8, 16 or 32 bits wide. The source and destination addresses can each either advance or stay fixed. When a transfer completes, the block sets a done flag. When a bus access fails, it sets an abort flag. Each flag can drive the interrupt line through its own enable bit. A self-clearing engine reset puts the sequencer back to its starting state and leaves the control settings as they were.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every readable register returns 0, and `m_req` and `irq` are low.
- R2: Register map on `reg_addr`:
  - 0x00 control:
    - bit 0 enable
    - bit 1 engine reset
    - bits 3:2 direction
    - bits 5:4 source address mode
    - bits 7:6 destination address mode
    - bits 20:19 peripheral width
    - bit 23 trigger
  - 0x04 source address
  - 0x08 destination address
  - 0x0C byte count (16 bits)
  - 0x10 interrupt enables (bit 0 abort, bit 1 done)
  - 0x14 interrupt flags (bit 0 abort, bit 1 done)
  - 0x18 current source address
  - 0x1C current destination address
  - 0x20 remaining byte count
  - 0x24 buffer pointer

  Read data appears one cycle after the address. Bits 1:0 of the source, destination and count registers always read 0.
- R3: Direction 00 (memory-to-memory) moves 32-bit units (`m_size`=2) without waiting. Each unit is a read of the current source address followed by a write of the same data to the current destination address. The address and write flag stay stable while a request waits for ready.
- R4: An address mode of 10 keeps that side's address fixed. Any other code advances it by the unit size in bytes after each completed write.
- R5: In direction 01 or 10, the width code 00/01/10 selects 32/8/16-bit units (`m_size` 2/0/1). Write data carries the read data with the bits above the unit width forced to 0. The engine issues no read while `periph_req` is low.
- R6: After each completed write the remaining count drops by the unit size. When it reaches 0, the trigger bit clears and the done flag sets. A count of 0 completes at once with no bus access.
- R7: An error response stops the transfer, sets the abort flag and clears the trigger. After that, no further request is issued until an engine reset. An engine reset followed by a new trigger runs a normal transfer.
- R8: Writing 1 to control bit 1 holds the engine reset for 4 cycles. Control bit 1 reads 1 during that time and then reads 0. The reset sets the remaining count and the buffer pointer to 0, abandons any transfer in progress, and leaves the other control fields unchanged.
- R9: While the enable bit is 0, a set trigger issues no request and stays set. Clearing the enable bit during a transfer drops `m_req` within two cycles. Setting it again restarts the transfer from the programmed addresses.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq` is high when any flag is set together with its enable bit.
- R11: With direction code 11 a trigger issues no bus request and the trigger bit stays set.
- R12: The buffer pointer holds the number of bytes waiting in the holding buffer. It is 0 whenever no write is pending, including after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| periph_req | input | 1 | Peripheral ready for the next unit |
| m_req | output | 1 | Bus access request |
| m_write | output | 1 | 1 = write, 0 = read |
| m_addr | output | 32 | Bus address |
| m_size | output | 2 | Unit size: 0 byte, 1 half-word, 2 word |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, valid with ready |
| m_ready | input | 1 | Access completes this cycle |
| m_error | input | 1 | Access failed, qualified by ready |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume the following about the bus: it answers each request with a single-cycle ready, it raises error only together with ready, and it holds read data steady while ready is high. The bus model in the bench drives ready and error on the falling edge after a random latency of zero to two cycles. It injects error only on a chosen access number. Every programmed address and count is word aligned, which keeps each unit count a whole number. Software changes the enable bit in the middle of a transfer only in the one directed case that checks the forced return to idle.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int REG_AW = 6;
  localparam int WORD_W = 32;

  localparam logic [REG_AW-1:0] OFF_CTRL  = 6'h00;
  localparam logic [REG_AW-1:0] OFF_SRC   = 6'h04;
  localparam logic [REG_AW-1:0] OFF_DST   = 6'h08;
  localparam logic [REG_AW-1:0] OFF_CNT   = 6'h0C;
  localparam logic [REG_AW-1:0] OFF_IEN   = 6'h10;
  localparam logic [REG_AW-1:0] OFF_FLAG  = 6'h14;
  localparam logic [REG_AW-1:0] OFF_CSRC  = 6'h18;
  localparam logic [REG_AW-1:0] OFF_CDST  = 6'h1C;
  localparam logic [REG_AW-1:0] OFF_CCNT  = 6'h20;
  localparam logic [REG_AW-1:0] OFF_PTR   = 6'h24;

  localparam logic [1:0] DIR_M2M   = 2'b00;
  localparam logic [1:0] DIR_BAD   = 2'b11;
  localparam logic [1:0] ADR_FIXED = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAITP = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3
  } eng_state_e;

  typedef struct packed {
    logic       trig;
    logic [1:0] pwidth;
    logic [1:0] dmode;
    logic [1:0] smode;
    logic [1:0] dir;
    logic       en;
  } ctrl_t;

  // size code on the bus: 0 byte, 1 half-word, 2 word
  function automatic logic [1:0] unit_size(input logic [1:0] dir, input logic [1:0] pw);
    if (dir == DIR_M2M) return 2'd2;
    case (pw)
      2'b01:   return 2'd0;
      2'b10:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return WORD_W'(32'h0000_00FF);
      2'd1:    return WORD_W'(32'h0000_FFFF);
      default: return {WORD_W{1'b1}};
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              trig_clr,
  input  logic [AW-1:0]     cur_src,
  input  logic [AW-1:0]     cur_dst,
  input  logic [CW-1:0]     cur_cnt,
  input  logic [3:0]        ptr,
  input  logic [1:0]        flags,
  output ctrl_t             ctrl,
  output logic [AW-1:0]     src_base,
  output logic [AW-1:0]     dst_base,
  output logic [CW-1:0]     byte_cnt,
  output logic [1:0]        ien,
  output logic [1:0]        flag_w1c,
  output logic              eng_rst
);

  localparam int RCW = $clog2(RST_CYC + 1);

  logic [RCW-1:0] rst_cnt;
  logic           wr_ctrl;

  assign wr_ctrl  = reg_wr && (reg_addr == OFF_CTRL);
  assign eng_rst  = (rst_cnt != '0);
  assign flag_w1c = (reg_wr && reg_addr == OFF_FLAG) ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      src_base <= '0;
      dst_base <= '0;
      byte_cnt <= '0;
      ien      <= '0;
      rst_cnt  <= '0;
    end else begin
      if (wr_ctrl && reg_wdata[1]) rst_cnt <= RCW'(RST_CYC);
      else if (rst_cnt != '0)      rst_cnt <= rst_cnt - 1'b1;

      if (wr_ctrl) begin
        ctrl.en     <= reg_wdata[0];
        ctrl.dir    <= reg_wdata[3:2];
        ctrl.smode  <= reg_wdata[5:4];
        ctrl.dmode  <= reg_wdata[7:6];
        ctrl.pwidth <= reg_wdata[20:19];
        ctrl.trig   <= reg_wdata[23];
      end
      if (trig_clr) ctrl.trig <= 1'b0;

      if (reg_wr && reg_addr == OFF_SRC) src_base <= {reg_wdata[AW-1:2], 2'b00};
      if (reg_wr && reg_addr == OFF_DST) dst_base <= {reg_wdata[AW-1:2], 2'b00};
      if (reg_wr && reg_addr == OFF_CNT) byte_cnt <= {reg_wdata[CW-1:2], 2'b00};
      if (reg_wr && reg_addr == OFF_IEN) ien      <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        OFF_CTRL: reg_rdata <= {8'd0, ctrl.trig, 2'd0, ctrl.pwidth, 11'd0,
                                ctrl.dmode, ctrl.smode, ctrl.dir, eng_rst, ctrl.en};
        OFF_SRC:  reg_rdata <= WORD_W'(src_base);
        OFF_DST:  reg_rdata <= WORD_W'(dst_base);
        OFF_CNT:  reg_rdata <= WORD_W'(byte_cnt);
        OFF_IEN:  reg_rdata <= WORD_W'(ien);
        OFF_FLAG: reg_rdata <= WORD_W'(flags);
        OFF_CSRC: reg_rdata <= WORD_W'(cur_src);
        OFF_CDST: reg_rdata <= WORD_W'(cur_dst);
        OFF_CCNT: reg_rdata <= WORD_W'(cur_cnt);
        OFF_PTR:  reg_rdata <= WORD_W'(ptr);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R6: a completion or abort clears the trigger on the following cycle
  p_trig_drop_r6: assert property (@(posedge clk) disable iff (rst)
    trig_clr |=> !ctrl.trig);

  // R8: the engine reset window counts down unless reloaded
  p_rst_window_r8: assert property (@(posedge clk) disable iff (rst)
    (eng_rst && !(wr_ctrl && reg_wdata[1])) |=> (rst_cnt < $past(rst_cnt)));

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_rst,
  input  ctrl_t             ctrl,
  input  logic [AW-1:0]     src_base,
  input  logic [AW-1:0]     dst_base,
  input  logic [CW-1:0]     byte_cnt,
  input  logic              periph_req,
  output logic              m_req,
  output logic              m_write,
  output logic [AW-1:0]     m_addr,
  output logic [1:0]        m_size,
  output logic [WORD_W-1:0] m_wdata,
  input  logic [WORD_W-1:0] m_rdata,
  input  logic              m_ready,
  input  logic              m_error,
  output logic [AW-1:0]     cur_src,
  output logic [AW-1:0]     cur_dst,
  output logic [CW-1:0]     cur_cnt,
  output logic [3:0]        ptr,
  output logic              done_p,
  output logic              abort_p,
  output logic              trig_clr
);

  eng_state_e        state;
  logic              halted;
  logic [1:0]        size_q;
  logic              periph_q, sinc_q, dinc_q;
  logic [WORD_W-1:0] hold_q;
  logic [2:0]        step;
  logic              start_ok;

  assign step     = size_bytes(size_q);
  assign start_ok = ctrl.trig && !halted && !trig_clr && (ctrl.dir != DIR_BAD);

  assign m_req   = (state == ST_READ) || (state == ST_WRITE);
  assign m_write = (state == ST_WRITE);
  assign m_addr  = (state == ST_WRITE) ? cur_dst : cur_src;
  assign m_size  = size_q;
  assign m_wdata = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      halted   <= 1'b0;
      hold_q   <= '0;
      ptr      <= '0;
      cur_src  <= '0;
      cur_dst  <= '0;
      cur_cnt  <= '0;
      size_q   <= 2'd2;
      periph_q <= 1'b0;
      sinc_q   <= 1'b0;
      dinc_q   <= 1'b0;
      done_p   <= 1'b0;
      abort_p  <= 1'b0;
      trig_clr <= 1'b0;
    end else if (eng_rst) begin
      state    <= ST_IDLE;
      halted   <= 1'b0;
      hold_q   <= '0;
      ptr      <= '0;
      cur_cnt  <= '0;
      done_p   <= 1'b0;
      abort_p  <= 1'b0;
      trig_clr <= 1'b0;
    end else begin
      done_p   <= 1'b0;
      abort_p  <= 1'b0;
      trig_clr <= 1'b0;
      if (!ctrl.en) begin
        state <= ST_IDLE;
        ptr   <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start_ok) begin
              cur_src  <= src_base;
              cur_dst  <= dst_base;
              cur_cnt  <= byte_cnt;
              size_q   <= unit_size(ctrl.dir, ctrl.pwidth);
              periph_q <= (ctrl.dir != DIR_M2M);
              sinc_q   <= (ctrl.smode != ADR_FIXED);
              dinc_q   <= (ctrl.dmode != ADR_FIXED);
              if (byte_cnt == '0) begin
                done_p   <= 1'b1;
                trig_clr <= 1'b1;
              end else if (ctrl.dir != DIR_M2M) begin
                state <= ST_WAITP;
              end else begin
                state <= ST_READ;
              end
            end
          end
          ST_WAITP: begin
            if (periph_req) state <= ST_READ;
          end
          ST_READ: begin
            if (m_ready) begin
              if (m_error) begin
                halted   <= 1'b1;
                abort_p  <= 1'b1;
                trig_clr <= 1'b1;
                state    <= ST_IDLE;
              end else begin
                hold_q <= m_rdata & lane_mask(size_q);
                ptr    <= 4'(step);
                state  <= ST_WRITE;
              end
            end
          end
          ST_WRITE: begin
            if (m_ready) begin
              ptr <= '0;
              if (m_error) begin
                halted   <= 1'b1;
                abort_p  <= 1'b1;
                trig_clr <= 1'b1;
                state    <= ST_IDLE;
              end else begin
                if (sinc_q) cur_src <= cur_src + AW'(step);
                if (dinc_q) cur_dst <= cur_dst + AW'(step);
                cur_cnt <= cur_cnt - CW'(step);
                if (cur_cnt <= CW'(step)) begin
                  done_p   <= 1'b1;
                  trig_clr <= 1'b1;
                  state    <= ST_IDLE;
                end else if (periph_q) begin
                  state <= ST_WAITP;
                end else begin
                  state <= ST_READ;
                end
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: a pending access keeps its address and direction
  p_bus_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ready && ctrl.en && !eng_rst) |=> ($stable(m_addr) && $stable(m_write) && m_req));

  // R5: no read leaves the wait state while the peripheral is not ready
  p_wait_periph_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAITP && !periph_req) |=> !m_req);

  // R6: every accepted write lowers the remaining count by one unit
  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_write && m_ready && !m_error && ctrl.en && !eng_rst)
      |=> (cur_cnt == $past(cur_cnt) - CW'($past(step))));

  // R7: a halted engine stays off the bus
  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> !m_req);

  // R9: clearing the enable returns the master to idle
  p_enable_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |=> !m_req);

  // R11: the invalid direction code never starts a transfer
  p_bad_dir_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && ctrl.dir == DIR_BAD) |=> !m_req);

  // R12: the buffer only holds bytes while a write is pending
  p_ptr_write_r12: assert property (@(posedge clk) disable iff (rst)
    (ptr != '0) |-> (state == ST_WRITE));

endmodule

// File: rtl/dma_irq.sv
module dma_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic       done_p,
  input  logic       abort_p,
  input  logic [1:0] flag_w1c,
  input  logic [1:0] ien,
  output logic [1:0] flags,
  output logic       irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= 2'b00;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~flag_w1c) | {done_p, abort_p};
      irq   <= |(flags & ien);
    end
  end

  // R10: flags stay set until a one is written to them
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flags[1] && !flag_w1c[1]) |=> flags[1]);
  p_abort_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !flag_w1c[0]) |=> flags[0]);

  // R6: a completion always lands in the done flag
  p_done_set_r6: assert property (@(posedge clk) disable iff (rst)
    done_p |=> flags[1]);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              periph_req,
  output logic              m_req,
  output logic              m_write,
  output logic [AW-1:0]     m_addr,
  output logic [1:0]        m_size,
  output logic [WORD_W-1:0] m_wdata,
  input  logic [WORD_W-1:0] m_rdata,
  input  logic              m_ready,
  input  logic              m_error,
  output logic              irq
);

  ctrl_t         ctrl;
  logic [AW-1:0] src_base, dst_base, cur_src, cur_dst;
  logic [CW-1:0] byte_cnt, cur_cnt;
  logic [3:0]    ptr;
  logic [1:0]    ien, flags, flag_w1c;
  logic          eng_rst, trig_clr, done_p, abort_p;

  dma_regs #(.AW(AW), .CW(CW), .RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_clr(trig_clr),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt), .ptr(ptr),
    .flags(flags), .ctrl(ctrl), .src_base(src_base), .dst_base(dst_base),
    .byte_cnt(byte_cnt), .ien(ien), .flag_w1c(flag_w1c), .eng_rst(eng_rst)
  );

  dma_engine #(.AW(AW), .CW(CW)) u_eng (
    .clk(clk), .rst(rst), .eng_rst(eng_rst), .ctrl(ctrl),
    .src_base(src_base), .dst_base(dst_base), .byte_cnt(byte_cnt),
    .periph_req(periph_req), .m_req(m_req), .m_write(m_write),
    .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_ready(m_ready), .m_error(m_error), .cur_src(cur_src), .cur_dst(cur_dst),
    .cur_cnt(cur_cnt), .ptr(ptr), .done_p(done_p), .abort_p(abort_p),
    .trig_clr(trig_clr)
  );

  dma_irq u_irq (
    .clk(clk), .rst(rst), .done_p(done_p), .abort_p(abort_p),
    .flag_w1c(flag_w1c), .ien(ien), .flags(flags), .irq(irq)
  );

endmodule

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        periph_req = 1'b0;
  logic        m_req, m_write;
  logic [31:0] m_addr, m_wdata;
  logic [1:0]  m_size;
  logic [31:0] m_rdata = '0;
  logic        m_ready = 1'b0;
  logic        m_error = 1'b0;
  logic        irq;

  dma_chan_engine dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .m_req(m_req), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
    .m_error(m_error), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // bus log
  logic [31:0] lg_addr [0:511];
  logic [31:0] lg_data [0:511];
  logic        lg_wr   [0:511];
  logic [1:0]  lg_size [0:511];
  int n_log = 0;
  int err_idx = -1;
  int lat = 0;
  int preq_mode = 1;

  function automatic logic [31:0] rdf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] cw(input int en, input int rs, input int dir,
                                     input int sm, input int dm, input int pw, input int tg);
    return (32'(tg) << 23) | (32'(pw) << 19) | (32'(dm) << 6) | (32'(sm) << 4)
         | (32'(dir) << 2) | (32'(rs) << 1) | 32'(en);
  endfunction

  always @(negedge clk) begin
    case (preq_mode)
      0:       periph_req = 1'b0;
      1:       periph_req = 1'b1;
      default: periph_req = (($urandom % 10) < 7);
    endcase
  end

  always @(negedge clk) begin
    if (m_ready) begin
      m_ready = 1'b0;
      m_error = 1'b0;
    end else if (m_req && !rst) begin
      if (lat == 0) begin
        m_ready = 1'b1;
        m_rdata = rdf(m_addr);
        if (n_log == err_idx) m_error = 1'b1;
        if (n_log < 512) begin
          lg_addr[n_log] = m_addr;
          lg_data[n_log] = m_wdata;
          lg_wr[n_log]   = m_write;
          lg_size[n_log] = m_size;
        end
        n_log = n_log + 1;
        lat = $urandom % 3;
      end else begin
        lat = lat - 1;
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_trig_low(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(6'h00, v);
      if (!v[23]) return;
    end
    chk({tag, " trigger self-clear"}, 32'd1, 32'd0);
  endtask

  task automatic prog(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    wr(6'h04, s);
    wr(6'h08, d);
    wr(6'h0C, c);
  endtask

  task automatic verify(input string tag, input int dir, input int sm, input int dm,
                        input int pw, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] c);
    int sc, st, units;
    logic [31:0] es, ed, mask;
    sc = (dir == 0) ? 2 : (pw == 1) ? 0 : (pw == 2) ? 1 : 2;
    st = 1 << sc;
    mask = (sc == 0) ? 32'hFF : (sc == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    units = int'(c) / st;
    chk({tag, " access count"}, 32'(n_log), 32'(2 * units));
    for (int k = 0; k < units && 2 * k + 1 < n_log; k++) begin
      es = s + ((sm == 2) ? 32'd0 : 32'(k * st));
      ed = d + ((dm == 2) ? 32'd0 : 32'(k * st));
      chk({tag, " read addr/dir/size"}, {lg_addr[2*k][29:0], lg_wr[2*k], 1'b0} ^ 32'(lg_size[2*k]),
          {es[29:0], 1'b0, 1'b0} ^ 32'(sc));
      chk({tag, " write addr/dir/size"}, {lg_addr[2*k+1][29:0], lg_wr[2*k+1], 1'b0} ^ 32'(lg_size[2*k+1]),
          {ed[29:0], 1'b1, 1'b0} ^ 32'(sc));
      chk({tag, " write data"}, lg_data[2*k+1], rdf(es) & mask);
    end
  endtask

  task automatic finish_run(input string tag, input int dir, input int sm, input int dm,
                            input int pw, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] c);
    logic [31:0] v;
    wait_trig_low(tag);
    idle(3);
    verify(tag, dir, sm, dm, pw, s, d, c);
    rd(6'h20, v); chk({tag, " R6 remaining count"}, v, 32'd0);
    rd(6'h14, v); chk({tag, " R6 done flag"}, v, 32'd2);
    rd(6'h24, v); chk({tag, " R12 pointer idle"}, v, 32'd0);
    wr(6'h14, 32'd3);
  endtask

  task automatic run(input string tag, input int dir, input int sm, input int dm,
                     input int pw, input logic [31:0] s, input logic [31:0] d,
                     input logic [31:0] c);
    prog(s, d, c);
    n_log = 0;
    wr(6'h00, cw(1, 0, dir, sm, dm, pw, 1));
    finish_run(tag, dir, sm, dm, pw, s, d, c);
  endtask

  initial begin
    logic [31:0] v;
    int nl;
    void'($urandom(32'd20240607));
    idle(5);
    rst = 1'b0;

    // R1 reset state
    chk("R1 m_req", 32'(m_req), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    for (int a = 0; a < 10; a++) begin
      rd(6'(a * 4), v);
      chk("R1 register zero", v, 32'd0);
    end

    // R2 register access and alignment
    wr(6'h04, 32'h0000_1003); rd(6'h04, v); chk("R2 source aligned", v, 32'h0000_1000);
    wr(6'h08, 32'hABCD_0002); rd(6'h08, v); chk("R2 dest aligned", v, 32'hABCD_0000);
    wr(6'h0C, 32'h0001_0017); rd(6'h0C, v); chk("R2 count aligned", v, 32'h0000_0014);
    wr(6'h10, 32'd3);         rd(6'h10, v); chk("R2 enables", v, 32'd3);
    wr(6'h10, 32'd0);
    wr(6'h00, cw(0, 0, 1, 2, 2, 2, 0)); rd(6'h00, v);
    chk("R2 control fields", v, cw(0, 0, 1, 2, 2, 2, 0));
    wr(6'h00, 32'd0);

    // R3 memory to memory, incrementing
    preq_mode = 0;
    run("R3 m2m", 0, 0, 0, 0, 32'h0000_0100, 32'h0000_0400, 32'd12);

    // R4 fixed source, reserved code increments
    run("R4 fixed src", 0, 2, 0, 0, 32'h0000_0200, 32'h0000_0800, 32'd16);
    run("R4 fixed dst rsv src", 0, 1, 2, 0, 32'h0000_0300, 32'h0000_0900, 32'd8);

    // R5 peripheral byte mode waits for periph_req
    prog(32'h0000_1000, 32'h0000_2000, 32'd8);
    n_log = 0;
    wr(6'h00, cw(1, 0, 1, 0, 0, 1, 1));
    idle(40);
    chk("R5 no read while periph_req low", 32'(n_log), 32'd0);
    preq_mode = 1;
    finish_run("R5 p2m byte", 1, 0, 0, 1, 32'h0000_1000, 32'h0000_2000, 32'd8);
    preq_mode = 2;
    run("R5 m2p half", 2, 0, 2, 2, 32'h0000_3000, 32'h0000_4000, 32'd12);
    run("R5 p2m word", 1, 2, 0, 0, 32'h0000_5000, 32'h0000_6000, 32'd8);

    // R6 zero count
    run("R6 zero count", 0, 0, 0, 0, 32'h0000_0100, 32'h0000_0200, 32'd0);

    // R7 bus error, then recovery
    wr(6'h10, 32'd1);
    prog(32'h0000_0200, 32'h0000_0600, 32'd12);
    n_log = 0; err_idx = 1;
    wr(6'h00, cw(1, 0, 0, 0, 0, 0, 1));
    wait_trig_low("R7 abort");
    idle(3);
    rd(6'h14, v); chk("R7 abort flag", v, 32'd1);
    chk("R10 abort irq", 32'(irq), 32'd1);
    nl = n_log;
    idle(30);
    chk("R7 halted no access", 32'(n_log), 32'(nl));
    chk("R7 m_req low", 32'(m_req), 32'd0);
    err_idx = -1;
    wr(6'h00, cw(1, 1, 0, 0, 0, 0, 0));
    idle(8);
    wr(6'h14, 32'd3);
    wr(6'h10, 32'd0);
    run("R7 recovery", 0, 0, 0, 0, 32'h0000_0200, 32'h0000_0600, 32'd12);

    // R8 engine reset mid transfer
    preq_mode = 0;
    prog(32'h0000_0700, 32'h0000_0A00, 32'd8);
    n_log = 0;
    wr(6'h00, cw(1, 0, 1, 0, 0, 1, 1));
    idle(20);
    rd(6'h20, v); chk("R8 count loaded", v, 32'd8);
    wr(6'h00, cw(1, 1, 1, 0, 0, 1, 0));
    rd(6'h00, v); chk("R8 reset bit visible", v, cw(1, 1, 1, 0, 0, 1, 0));
    idle(10);
    rd(6'h00, v); chk("R8 reset bit cleared, fields kept", v, cw(1, 0, 1, 0, 0, 1, 0));
    rd(6'h20, v); chk("R8 count cleared", v, 32'd0);
    rd(6'h24, v); chk("R8 pointer cleared", v, 32'd0);
    preq_mode = 1;
    idle(10);
    chk("R8 abandoned transfer", 32'(n_log), 32'd0);

    // R9 enable low blocks the trigger
    prog(32'h0000_0100, 32'h0000_0500, 32'd64);
    n_log = 0;
    wr(6'h00, cw(0, 0, 0, 0, 0, 0, 1));
    idle(30);
    chk("R9 no access while disabled", 32'(n_log), 32'd0);
    rd(6'h00, v); chk("R9 trigger held", 32'(v[23]), 32'd1);
    wr(6'h00, cw(1, 0, 0, 0, 0, 0, 1));
    idle(6);
    wr(6'h00, cw(0, 0, 0, 0, 0, 0, 1));
    idle(2);
    chk("R9 m_req dropped", 32'(m_req), 32'd0);
    idle(20);
    n_log = 0;
    wr(6'h00, cw(1, 0, 0, 0, 0, 0, 1));
    finish_run("R9 restart", 0, 0, 0, 0, 32'h0000_0100, 32'h0000_0500, 32'd64);

    // R10 interrupt masking and write-one-to-clear
    prog(32'h0000_0040, 32'h0000_0080, 32'd4);
    n_log = 0;
    wr(6'h00, cw(1, 0, 0, 0, 0, 0, 1));
    wait_trig_low("R10");
    idle(3);
    chk("R10 masked irq", 32'(irq), 32'd0);
    wr(6'h10, 32'd2); idle(3);
    chk("R10 done irq", 32'(irq), 32'd1);
    wr(6'h14, 32'd1);
    rd(6'h14, v); chk("R10 clear other bit only", v, 32'd2);
    wr(6'h14, 32'd2); idle(3);
    rd(6'h14, v); chk("R10 flag cleared", v, 32'd0);
    chk("R10 irq cleared", 32'(irq), 32'd0);
    wr(6'h10, 32'd0);

    // R11 invalid direction
    n_log = 0;
    wr(6'h00, cw(1, 0, 3, 0, 0, 0, 1));
    idle(30);
    chk("R11 no access", 32'(n_log), 32'd0);
    rd(6'h00, v); chk("R11 trigger stays", 32'(v[23]), 32'd1);
    wr(6'h00, 32'd0);

    // random mix
    preq_mode = 2;
    for (int it = 0; it < 24; it++) begin
      int dir, sm, dm, pw;
      logic [31:0] s, d, c;
      dir = $urandom % 3;
      sm  = (($urandom % 3) == 0) ? 2 : ($urandom % 2);
      dm  = (($urandom % 3) == 0) ? 2 : (($urandom % 2) * 3);
      pw  = $urandom % 3;
      s   = 32'h0001_0000 + 32'(($urandom % 256) * 4);
      d   = 32'h0002_0000 + 32'(($urandom % 256) * 4);
      c   = 32'((1 + $urandom % 4) * 4);
      run("R4 R5 random", dir, sm, dm, pw, s, d, c);
    end

    summary();
    $finish;
  end

endmodule